// File: doc/BRIEF.md
# Posted Write Burst Coalescer

This block sits between a host write port and a burst-oriented output bus. The host hands it single posted 32-bit writes, each with a double-word address, data and four byte enables. The writes are queued in a posting buffer. A write that lands just after the previous one, or slightly past it, is grouped with it into one run. The output side then sends each run as one burst. The burst carries its start address once, and the data beats that follow have implied addresses that rise by one double word per beat.

When a run skips a few double words, the missing positions go out as filler beats with every byte enable cleared, so the run stays one burst. Three things close a run: a jump that is too large, a write that goes backwards, or the flush policy. The flush policy has two triggers: the buffer fills to a threshold, or the host goes quiet for a set number of cycles. The input and output sides work independently, so a write can be taken in the same cycle a beat leaves.

Top module: `wpost_coalescer`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: The first beat of every burst has `out_sop`=1 and `out_addr` equal to the burst's start address. Every following beat of that burst has `out_sop`=0 and the same `out_addr`. Once a non-final beat is taken, the next beat of that burst is offered in the next cycle.
- R3: A write whose double-word address (`in_addr[31:2]`) is exactly one above that of the previous write joins the open burst. Its data and byte enables leave in acceptance order.
- R4: When the double-word address is k above the previous one, with 2 <= k <= MAX_GAP+1 (default MAX_GAP=1), the write joins the open burst. The k-1 skipped positions are emitted first, each as a filler beat with `out_be`=4'b0000 and `out_last`=0.
- R5: A write that is more than MAX_GAP+1 double words above the previous write closes the open burst and starts a new one. So does a write whose address is equal to or below the previous one.
- R6: When the buffer holds THRESH entries (default 8) while a burst is open, that burst is closed and becomes eligible for output.
- R7: A burst that stays open through IDLE_LIMIT (default 16) consecutive cycles without an accepted write is closed and becomes eligible for output.
- R8: No beat of a burst is offered (`out_valid`=1) before that burst is closed.
- R9: `out_last`=1 exactly on the final real beat of each burst. After a taken last beat, the next offered beat starts a new burst.
- R10: `in_ready` is 0 exactly when the buffer holds DEPTH entries (default 8), and no write is taken then.
- R11: While `out_valid`=1 and `out_ready`=0, all output fields hold their values into the next cycle.
- R12: A write can be accepted in the same cycle that a beat is taken, with no loss or reordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Host offers a write |
| in_ready | output | 1 | Buffer can take a write |
| in_addr | input | 32 | Byte address of the write, double-word aligned |
| in_data | input | 32 | Write data |
| in_be | input | 4 | Byte enables, active high |
| out_valid | output | 1 | A beat is offered |
| out_ready | input | 1 | Consumer takes the beat |
| out_sop | output | 1 | Beat is the first of its burst |
| out_addr | output | 32 | Start address of the current burst |
| out_data | output | 32 | Beat data (zero on filler beats) |
| out_be | output | 4 | Beat byte enables, zero on filler beats |
| out_last | output | 1 | Beat is the last of its burst |

## Verification
The hardest state to reach from the ports combines several conditions at once. The buffer must be full and its open burst just sealed by the threshold. The consumer must be stalled. And a filler beat or the last beat of an older burst must sit at the head, all while new writes are pushing against `in_ready`. The stimulus gets there with directed runs that withhold `out_ready` while sequential writes fill the buffer. These runs are followed by long random phases in which addresses mostly step by one double word, sometimes skip one or two, and sometimes jump or go backwards, while `out_ready` toggles at random. A behavioural queue model predicts every output field on every cycle, and per-scenario counts of burst starts, beats and fillers confirm the close rules.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

  localparam int unsigned BYTE_W = 8;

  // Kind of beat presented at the head of the output side.
  typedef enum logic [1:0] {
    BEAT_NONE = 2'd0,
    BEAT_REAL = 2'd1,
    BEAT_FILL = 2'd2
  } beat_kind_e;

endpackage

// File: rtl/wpc_fifo.sv
// Posting buffer: circular store with a one-bit tag per entry, head and
// head+1 tag visibility for end-of-burst detection.
module wpc_fifo #(
  parameter int W     = 68,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          push_flag,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head_data,
  output logic          next_flag,
  output logic [CW-1:0] count
);

  logic [W:0]    mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d, rd_nxt;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    logic [PW-1:0] r;
    r = p + PW'(1);
    if ((1 << PW) != DEPTH) begin
      if (p == PW'(DEPTH - 1)) r = '0;
    end
    return r;
  endfunction

  assign rd_nxt = ptr_inc(rd_q);

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = ptr_inc(wr_q);
    if (pop)  rd_d = rd_nxt;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= {push_flag, push_data};
  end

  assign head_data = mem[rd_q][W-1:0];
  assign next_flag = mem[rd_nxt][W];
  assign count     = cnt_q;

endmodule

// File: rtl/wpc_gather.sv
// Input side: classifies each accepted write against the open run,
// applies the flush policy and keeps the count of sealed bursts.
module wpc_gather #(
  parameter int AW         = 32,
  parameter int DEPTH      = 8,
  parameter int THRESH     = 8,
  parameter int IDLE_LIMIT = 16,
  parameter int MAX_GAP    = 1,
  localparam int CW        = $clog2(DEPTH + 1),
  localparam int IW        = $clog2(IDLE_LIMIT + 1),
  localparam int DWW       = AW - 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [DWW-1:0] in_dw,
  input  logic [CW-1:0]  fill_cnt,
  input  logic           burst_done,
  output logic           in_ready,
  output logic           push,
  output logic           push_sob,
  output logic           sealed_any
);

  localparam logic [CW-1:0]  DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0]  THR_C   = CW'(THRESH);
  localparam logic [IW-1:0]  IDLE_C  = IW'(IDLE_LIMIT);
  localparam logic [DWW-1:0] STEP_C  = DWW'(MAX_GAP + 1);

  logic           open_q, open_d;
  logic [DWW-1:0] last_q;
  logic           last_en;
  logic [IW-1:0]  idle_q, idle_d;
  logic [CW-1:0]  sealed_q, sealed_d;
  logic           acc, flush, seq, cont, close;
  logic [DWW-1:0] step;

  assign in_ready = (fill_cnt < DEPTH_C);
  assign acc      = in_valid & in_ready;
  assign flush    = open_q & ((fill_cnt >= THR_C) | (idle_q == IDLE_C));
  assign step     = in_dw - last_q;
  assign seq      = (in_dw > last_q) & (step <= STEP_C);
  assign cont     = open_q & ~flush & seq;
  assign close    = open_q & ~cont & (flush | acc);

  assign push     = acc;
  assign push_sob = ~cont;
  assign last_en  = acc;

  always_comb begin
    open_d   = acc | (open_q & ~flush);
    idle_d   = (acc | ~open_d) ? '0 : idle_q + IW'(1);
    sealed_d = sealed_q + CW'(close) - CW'(burst_done);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q   <= 1'b0;
      idle_q   <= '0;
      sealed_q <= '0;
      last_q   <= '0;
    end else begin
      open_q   <= open_d;
      idle_q   <= idle_d;
      sealed_q <= sealed_d;
      if (last_en) last_q <= in_dw;
    end
  end

  assign sealed_any = (sealed_q != '0);

endmodule

// File: rtl/wpc_emit.sv
// Output side: walks the head burst, inserts filler beats for skipped
// double words and marks start and end of each burst.
module wpc_emit
  import wpc_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  localparam int BEW = DW / BYTE_W,
  localparam int DWW = AW - 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           avail,
  input  logic [AW-1:0]  head_addr,
  input  logic [DW-1:0]  head_data,
  input  logic [BEW-1:0] head_be,
  input  logic           head_alone,
  input  logic           next_sob,
  input  logic           out_ready,
  output logic           out_valid,
  output logic           out_sop,
  output logic [AW-1:0]  out_addr,
  output logic [DW-1:0]  out_data,
  output logic [BEW-1:0] out_be,
  output logic           out_last,
  output logic           pop,
  output logic           burst_done
);

  logic           busy_q, busy_d;
  logic [DWW-1:0] exp_q, exp_d;
  logic [AW-1:0]  base_q;
  logic           base_en;
  logic           hs, last;
  beat_kind_e     kind;

  always_comb begin
    if (!avail)                                 kind = BEAT_NONE;
    else if (!busy_q || head_addr[AW-1:2] == exp_q) kind = BEAT_REAL;
    else                                        kind = BEAT_FILL;
  end

  assign last       = (kind == BEAT_REAL) & (head_alone | next_sob);
  assign hs         = avail & out_ready;
  assign pop        = hs & (kind == BEAT_REAL);
  assign burst_done = hs & last;
  assign base_en    = hs & ~busy_q;

  assign out_valid  = avail;
  assign out_sop    = ~busy_q;
  assign out_addr   = busy_q ? base_q : head_addr;
  assign out_be     = (kind == BEAT_REAL) ? head_be : '0;
  assign out_data   = (kind == BEAT_REAL) ? head_data : '0;
  assign out_last   = last;

  always_comb begin
    busy_d = busy_q;
    exp_d  = exp_q;
    if (hs) begin
      busy_d = ~last;
      exp_d  = (busy_q ? exp_q : head_addr[AW-1:2]) + DWW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      exp_q  <= '0;
      base_q <= '0;
    end else begin
      busy_q <= busy_d;
      exp_q  <= exp_d;
      if (base_en) base_q <= head_addr;
    end
  end

endmodule

// File: rtl/wpost_coalescer.sv
module wpost_coalescer
  import wpc_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int DEPTH      = 8,
  parameter int THRESH     = 8,
  parameter int IDLE_LIMIT = 16,
  parameter int MAX_GAP    = 1,
  localparam int BEW       = DW / BYTE_W,
  localparam int CW        = $clog2(DEPTH + 1),
  localparam int EW        = AW + BEW + DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [AW-1:0]  in_addr,
  input  logic [DW-1:0]  in_data,
  input  logic [BEW-1:0] in_be,
  output logic           out_valid,
  input  logic           out_ready,
  output logic           out_sop,
  output logic [AW-1:0]  out_addr,
  output logic [DW-1:0]  out_data,
  output logic [BEW-1:0] out_be,
  output logic           out_last
);

  logic [1:0]    rsync_q;
  logic          rst_int_n;
  logic          push, push_sob, pop, burst_done, sealed_any, next_sob;
  logic [CW-1:0] fill_cnt;
  logic [EW-1:0] head_ent;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  wpc_gather #(
    .AW(AW), .DEPTH(DEPTH), .THRESH(THRESH),
    .IDLE_LIMIT(IDLE_LIMIT), .MAX_GAP(MAX_GAP)
  ) u_gather (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .in_valid   (in_valid),
    .in_dw      (in_addr[AW-1:2]),
    .fill_cnt   (fill_cnt),
    .burst_done (burst_done),
    .in_ready   (in_ready),
    .push       (push),
    .push_sob   (push_sob),
    .sealed_any (sealed_any)
  );

  wpc_fifo #(.W(EW), .DEPTH(DEPTH)) u_buf (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .push      (push),
    .push_flag (push_sob),
    .push_data ({in_addr, in_be, in_data}),
    .pop       (pop),
    .head_data (head_ent),
    .next_flag (next_sob),
    .count     (fill_cnt)
  );

  wpc_emit #(.AW(AW), .DW(DW)) u_emit (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .avail      (sealed_any),
    .head_addr  (head_ent[EW-1 -: AW]),
    .head_data  (head_ent[DW-1:0]),
    .head_be    (head_ent[DW +: BEW]),
    .head_alone (fill_cnt == CW'(1)),
    .next_sob   (next_sob),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_sop    (out_sop),
    .out_addr   (out_addr),
    .out_data   (out_data),
    .out_be     (out_be),
    .out_last   (out_last),
    .pop        (pop),
    .burst_done (burst_done)
  );

endmodule

// File: rtl/wpc_chk.sv
module wpc_chk #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int BEW  = DW / 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic           out_sop,
  input logic [AW-1:0]  out_addr,
  input logic [DW-1:0]  out_data,
  input logic [BEW-1:0] out_be,
  input logic           out_last,
  input logic [CW-1:0]  fill_cnt
);

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid &&
      $stable({out_sop, out_addr, out_data, out_be, out_last}));

  // R2
  burst_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> out_valid && !out_sop && $stable(out_addr));

  // R9
  new_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid || out_sop);

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_cnt <= CW'(DEPTH)) && (!in_ready || fill_cnt != CW'(DEPTH)));

  // R8
  offer_backed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> fill_cnt != '0);

endmodule

bind wpost_coalescer wpc_chk #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_sop   (out_sop),
  .out_addr  (out_addr),
  .out_data  (out_data),
  .out_be    (out_be),
  .out_last  (out_last),
  .fill_cnt  (fill_cnt)
);

// File: tb/wpost_coalescer_tb.sv
`timescale 1ns/1ps
module wpost_coalescer_tb;

  localparam int DEPTH = 8;
  localparam int THRESH = 8;
  localparam int IDLE = 16;
  localparam int GAP = 1;

  logic clk, rst_n;
  logic in_valid, in_ready, out_valid, out_ready, out_sop, out_last;
  logic [31:0] in_addr, in_data, out_addr, out_data;
  logic [3:0] in_be, out_be;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  wpost_coalescer #(.DEPTH(DEPTH), .THRESH(THRESH), .IDLE_LIMIT(IDLE), .MAX_GAP(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .in_data(in_data), .in_be(in_be),
    .out_valid(out_valid), .out_ready(out_ready), .out_sop(out_sop),
    .out_addr(out_addr), .out_data(out_data), .out_be(out_be), .out_last(out_last)
  );

  initial begin
    clk = 0;
    forever #4 clk = ~clk;
  end

  // Behavioural model state
  typedef struct {
    logic [31:0] a;
    logic [31:0] d;
    logic [3:0]  b;
    bit          sob;
  } ent_t;
  ent_t q[$];
  bit m_open, m_busy;
  int unsigned m_last, m_exp, m_idle, m_closed;
  logic [31:0] m_base;

  // observed output statistics
  int n_sop, n_beats, n_fill, n_both;
  bit saw_full;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic beat_now(output bit ov, output bit rl, output bit lst);
    ov = (m_closed > 0) && (q.size() > 0);
    rl = 0;
    lst = 0;
    if (ov) begin
      rl = !m_busy || ((q[0].a >> 2) == m_exp);
      lst = rl && (q.size() == 1 || q[1].sob);
    end
  endtask

  task automatic compare();
    bit ov, rl, lst;
    beat_now(ov, rl, lst);
    chk(in_ready == (q.size() < DEPTH), "R10", "in_ready", 32'(in_ready), 32'(q.size() < DEPTH));
    chk(out_valid == ov, "R6 R7 R8", "out_valid", 32'(out_valid), 32'(ov));
    if (ov && out_valid) begin
      chk(out_sop == !m_busy, "R2 R5", "out_sop", 32'(out_sop), 32'(!m_busy));
      chk(out_addr == (m_busy ? m_base : q[0].a), "R2 R3 R5", "out_addr", out_addr,
          m_busy ? m_base : q[0].a);
      chk(out_be == (rl ? q[0].b : 4'h0), "R4", "out_be", 32'(out_be), 32'(rl ? q[0].b : 4'h0));
      if (rl) chk(out_data == q[0].d, "R3 R12", "out_data", out_data, q[0].d);
      chk(out_last == lst, "R9", "out_last", 32'(out_last), 32'(lst));
    end
  endtask

  task automatic model_update(input bit iv, input logic [31:0] ia, input logic [31:0] id,
                              input logic [3:0] ib, input bit ordy);
    bit ov, rl, lst, acc, hs, ftrig, seq, cont;
    int unsigned nd, ld;
    beat_now(ov, rl, lst);
    acc = iv && (q.size() < DEPTH);
    hs = ov && ordy;
    ftrig = m_open && (q.size() >= THRESH || m_idle >= IDLE);
    nd = ia >> 2;
    ld = m_last >> 2;
    seq = m_open && (nd > ld) && ((nd - ld) <= GAP + 1);
    cont = seq && !ftrig;
    if (hs) begin
      if (rl) begin
        if (!m_busy) begin
          m_base = q[0].a;
          m_exp = (q[0].a >> 2) + 1;
        end else m_exp++;
        m_busy = !lst;
        if (lst) m_closed--;
        void'(q.pop_front());
      end else m_exp++;
    end
    if (acc) begin
      q.push_back('{a: ia, d: id, b: ib, sob: !cont});
      if (m_open && !cont) m_closed++;
      m_open = 1;
      m_last = ia;
      m_idle = 0;
    end else if (ftrig) begin
      m_open = 0;
      m_closed++;
      m_idle = 0;
    end else if (m_open) m_idle++;
    else m_idle = 0;
  endtask

  task automatic step(input bit iv, input logic [31:0] ia, input logic [31:0] id,
                      input logic [3:0] ib, input bit ordy, output bit accepted);
    @(negedge clk);
    compare();
    accepted = iv && in_ready;
    if (!in_ready) saw_full = 1;
    in_valid = iv; in_addr = ia; in_data = id; in_be = ib; out_ready = ordy;
    if (out_valid && ordy) begin
      n_beats++;
      if (out_sop) n_sop++;
      if (out_be == 4'h0) n_fill++;
    end
    if (accepted && out_valid && ordy) n_both++;
    model_update(iv, ia, id, ib, ordy);
  endtask

  task automatic idle_for(input int n, input bit ordy);
    bit a;
    for (int i = 0; i < n; i++) step(0, 32'h0, 32'h0, 4'h0, ordy, a);
  endtask

  task automatic wr(input logic [31:0] ia, input bit ordy);
    bit a;
    do step(1, ia, $urandom, 4'(1 + $urandom_range(14)), ordy, a); while (!a);
  endtask

  task automatic snap(output int s, output int b, output int f);
    s = n_sop; b = n_beats; f = n_fill;
  endtask

  initial begin
    int s0, b0, f0;
    bit a;
    logic [31:0] na;
    rst_n = 0;
    in_valid = 0; in_addr = 0; in_data = 0; in_be = 0; out_ready = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(out_valid == 0, "R1", "out_valid after reset", 32'(out_valid), 0);
    chk(in_ready == 1, "R1", "in_ready after reset", 32'(in_ready), 1);
    rst_n = 1;
    idle_for(5, 1);

    // R3 R7 R8: sequential run, sealed only by idleness
    snap(s0, b0, f0);
    for (int i = 0; i < 5; i++) wr(32'h100 + 32'(4 * i), 1);
    idle_for(10, 1);
    chk(n_beats == b0, "R8", "beats before idle seal", 32'(n_beats - b0), 0);
    idle_for(20, 1);
    chk(n_sop - s0 == 1, "R7", "bursts from idle seal", 32'(n_sop - s0), 1);
    chk(n_beats - b0 == 5, "R3", "beats in run", 32'(n_beats - b0), 5);

    // R4: one skipped double word gives one filler
    snap(s0, b0, f0);
    wr(32'h200, 1); wr(32'h204, 1); wr(32'h20C, 1); wr(32'h210, 1);
    idle_for(30, 1);
    chk(n_sop - s0 == 1, "R4", "bursts with hole", 32'(n_sop - s0), 1);
    chk(n_fill - f0 == 1, "R4", "filler beats", 32'(n_fill - f0), 1);
    chk(n_beats - b0 == 5, "R4", "beats with hole", 32'(n_beats - b0), 5);

    // R5: too large a gap, and a backward step
    snap(s0, b0, f0);
    wr(32'h300, 1); wr(32'h30C, 1); wr(32'h400, 1); wr(32'h3F0, 1);
    idle_for(30, 1);
    chk(n_sop - s0 == 4, "R5", "bursts after breaks", 32'(n_sop - s0), 4);
    chk(n_fill - f0 == 0, "R5", "no fillers", 32'(n_fill - f0), 0);

    // R6 R10: stalled consumer, buffer fills, threshold seal
    snap(s0, b0, f0);
    saw_full = 0;
    for (int i = 0; i < 8; i++) wr(32'h600 + 32'(4 * i), 0);
    idle_for(3, 0);
    chk(saw_full, "R10", "in_ready dropped when full", 32'(saw_full), 1);
    chk(out_valid == 1, "R6", "threshold seal offers", 32'(out_valid), 1);
    for (int i = 8; i < 12; i++) wr(32'h600 + 32'(4 * i), 1);
    idle_for(30, 1);
    chk(n_sop - s0 == 2, "R6", "bursts after threshold", 32'(n_sop - s0), 2);
    chk(n_beats - b0 == 12, "R6", "beats after threshold", 32'(n_beats - b0), 12);

    // R12: writes stream in while bursts drain
    n_both = 0;
    for (int i = 0; i < 30; i++) wr(32'h800 + 32'(4 * i), 1);
    idle_for(30, 1);
    chk(n_both > 0, "R12", "concurrent accept and emit", 32'(n_both), 1);

    // Random mix of steps, holes, jumps and stalls
    na = 32'h1000;
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(99);
      if (r < 65) na = na + 4;
      else if (r < 75) na = na + 8;
      else if (r < 80) na = na + 12;
      else if (r < 90) na = na - 32'(4 * $urandom_range(3));
      else na = {$urandom_range(255), 12'h0} + 32'(4 * $urandom_range(15));
      step($urandom_range(99) < 70, na, $urandom, 4'(1 + $urandom_range(14)),
           $urandom_range(99) < 60, a);
      if ($urandom_range(199) == 0) idle_for(20, $urandom_range(1));
    end
    idle_for(60, 1);
    chk(q.size() == 0 && out_valid == 0, "R9", "drained at end", 32'(out_valid), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule